// File: doc/BRIEF.md
# Stop-and-Wait Latency Link

This block is a cycle-accurate stand-in for a narrow serial connection between two chips that carries one word at a time. A producer offers a word with `pushValid` and `pushData`. The word is taken only while `pushReady` is high. It then travels for a configurable number of wire cycles. After that it appears at the consumer side with `outValid` and `outData`, and it stays there until the consumer takes it with `popReq`. An acknowledgement then returns over its own configurable number of cycles. Only when that return is complete does the producer side reopen.

The link moves through four phases: empty, forwarding, delivered and returning. The word in flight is stored inside the block together with its phase. `occFull` reports the logical view: the link counts as holding a word from the edge that accepts the push up to the edge that accepts the pop. It reads empty while the acknowledgement is still returning, even though a new push cannot yet be taken. Seen from its ports, the block behaves like a one-entry mailbox whose handshakes are stretched in time.

Top module: `edge_link`

## Requirements
- R1: With `rst` high at a rising edge, the block returns to the empty phase: `pushReady`=1, `outValid`=0, `occFull`=0, `outData`=0.
- R2: A push is accepted at a rising edge only when `pushValid`=1 and `pushReady`=1, and that edge captures `pushData`. A `pushValid` offered while `pushReady`=0 leaves the phase and the stored word unchanged, so the word later delivered is the one first accepted.
- R3: After the edge that accepts a push, `outValid` goes to 1 exactly FWD_LAT+1 rising edges later, and it is 0 at every edge before that.
- R4: `outValid` is 1 only in the delivered phase. While `outValid`=0, `outData` reads all zeros. While `outValid`=1, `outData` holds the captured word unchanged.
- R5: A pop is acted on only at an edge with `outValid`=1 and `popReq`=1, and that edge clears `outValid`. A `popReq` at any other time has no effect.
- R6: After the edge that accepts a pop, `pushReady` returns to 1 exactly ACK_LAT+1 rising edges later. `pushReady` stays 0 from the edge that accepts a push until then.
- R7: `occFull` is 1 from the edge that accepts a push to the edge that accepts the matching pop. It is 0 in the empty phase and while the acknowledgement returns.
- R8: With WIDTH=64 and FWD_LAT=66, a pushed word is seen at `outData` with `outValid`=1 after exactly 67 rising edges that follow the accepting edge.
- R9: With FWD_LAT=0 and ACK_LAT=0, the forwarding and returning phases each last exactly one cycle.
- R10: Delivered words come out in push order, each accepted word exactly once: no loss and no duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pushValid | input | 1 | Producer offers a word |
| pushData | input | WIDTH | Word offered by the producer |
| pushReady | output | 1 | Link is empty and can take a word |
| outValid | output | 1 | A delivered word waits for the consumer |
| outData | output | WIDTH | Delivered word, zero when `outValid` is low |
| popReq | input | 1 | Consumer takes the delivered word |
| occFull | output | 1 | Link logically holds a word |

## Verification
Two things can fall in the same cycle: a producer push offered while a word is still being delivered or its acknowledgement is still returning, and a consumer pop raised when nothing has been delivered. Random streams of pushes and pops are driven at high density into three instances with different latency settings, including zero latency and a 66-cycle forward wire. The stray push and the stray pop therefore land in every phase, and they often coincide with a countdown reaching zero. Each of these cycles is judged against a phase-and-countdown model written from the requirements. A separate one-entry scoreboard confirms that each popped word is the last accepted push and that no word is lost or duplicated.

// File: rtl/edge_link_pkg.sv
package edge_link_pkg;

  typedef enum logic [1:0] {
    PH_EMPTY = 2'd0,
    PH_FWD   = 2'd1,
    PH_HELD  = 2'd2,
    PH_RET   = 2'd3
  } linkPhase_t;

  typedef struct packed {
    logic clearWord;
    logic loadWord;
    logic showWord;
  } linkStrobe_t;

endpackage

// File: rtl/edge_link_ctrl.sv
module edge_link_ctrl
  import edge_link_pkg::*;
#(
  parameter int FWD_LAT = 4,
  parameter int ACK_LAT = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pushValid,
  input  logic        popReq,
  output logic        pushReady,
  output logic        outValid,
  output logic        occFull,
  output linkStrobe_t strb
);

  localparam int MAX_LAT = (FWD_LAT > ACK_LAT) ? FWD_LAT : ACK_LAT;
  localparam int CNT_W   = (MAX_LAT < 1) ? 1 : $clog2(MAX_LAT + 1);
  localparam logic [CNT_W-1:0] FWD_LOAD = CNT_W'(FWD_LAT);
  localparam logic [CNT_W-1:0] ACK_LOAD = CNT_W'(ACK_LAT);

  linkPhase_t       phase, phaseNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             pushTake, popTake;

  assign pushTake = pushValid && (phase == PH_EMPTY);
  assign popTake  = popReq && (phase == PH_HELD);

  always_comb begin
    phaseNext = phase;
    cntNext   = cnt;
    unique case (phase)
      PH_EMPTY: if (pushTake) begin
        phaseNext = PH_FWD;
        cntNext   = FWD_LOAD;
      end
      PH_FWD: begin
        if (cnt != '0) cntNext = cnt - CNT_W'(1);
        else           phaseNext = PH_HELD;
      end
      PH_HELD: if (popTake) begin
        phaseNext = PH_RET;
        cntNext   = ACK_LOAD;
      end
      PH_RET: begin
        if (cnt != '0) cntNext = cnt - CNT_W'(1);
        else           phaseNext = PH_EMPTY;
      end
      default: phaseNext = PH_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_EMPTY;
      cnt   <= '0;
    end else begin
      phase <= phaseNext;
      cnt   <= cntNext;
    end
  end

  assign pushReady      = (phase == PH_EMPTY);
  assign outValid       = (phase == PH_HELD);
  assign occFull        = (phase == PH_FWD) || (phase == PH_HELD);
  assign strb.clearWord = rst;
  assign strb.loadWord  = pushTake;
  assign strb.showWord  = (phase == PH_HELD);

  // R2: an accepted push opens the forward countdown at full latency
  a_r2_push_loads: assert property (@(posedge clk) disable iff (rst)
    (pushValid && pushReady) |=> (phase == PH_FWD && cnt == FWD_LOAD));

  // R2: a push offered while busy does not disturb the held word's phase
  a_r2_push_ignored_held: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HELD && !popReq) |=> (phase == PH_HELD));

  // R3: forward countdown steps down by one per cycle
  a_r3_fwd_step: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FWD && cnt != '0) |=> (phase == PH_FWD && cnt == $past(cnt) - CNT_W'(1)));

  // R3: delivery only ever follows an exhausted forward countdown
  a_r3_deliver_after_fwd: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> ($past(phase) == PH_FWD && $past(cnt) == '0));

  // R5: an accepted pop opens the return countdown at full latency
  a_r5_pop_loads: assert property (@(posedge clk) disable iff (rst)
    (outValid && popReq) |=> (phase == PH_RET && cnt == ACK_LOAD));

  // R6: return countdown steps down by one per cycle
  a_r6_ret_step: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RET && cnt != '0) |=> (phase == PH_RET && cnt == $past(cnt) - CNT_W'(1)));

  // R7: occupancy drops only through an accepted pop
  a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(occFull) |-> ($past(outValid) && $past(popReq)));

endmodule

// File: rtl/edge_link_data.sv
module edge_link_data
  import edge_link_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  linkStrobe_t      strb,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] outData
);

  logic [WIDTH-1:0] wordHeld;

  always_ff @(posedge clk) begin
    if (strb.clearWord)     wordHeld <= '0;
    else if (strb.loadWord) wordHeld <= pushData;
  end

  assign outData = strb.showWord ? wordHeld : '0;

  // R4: nothing leaks to the consumer outside the delivered phase
  a_r4_hidden: assert property (@(posedge clk) disable iff (strb.clearWord)
    !strb.showWord |-> (outData == '0));

  // R4: the delivered word does not move while shown
  a_r4_stable: assert property (@(posedge clk) disable iff (strb.clearWord)
    (strb.showWord && $past(strb.showWord) && !$past(strb.clearWord)) |-> $stable(outData));

endmodule

// File: rtl/edge_link.sv
module edge_link
  import edge_link_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int FWD_LAT = 4,
  parameter int ACK_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pushValid,
  input  logic [WIDTH-1:0] pushData,
  output logic             pushReady,
  output logic             outValid,
  output logic [WIDTH-1:0] outData,
  input  logic             popReq,
  output logic             occFull
);

  linkStrobe_t strb;

  edge_link_ctrl #(.FWD_LAT(FWD_LAT), .ACK_LAT(ACK_LAT)) uCtrl (
    .clk(clk), .rst(rst), .pushValid(pushValid), .popReq(popReq),
    .pushReady(pushReady), .outValid(outValid), .occFull(occFull), .strb(strb)
  );

  edge_link_data #(.WIDTH(WIDTH)) uData (
    .clk(clk), .strb(strb), .pushData(pushData), .outData(outData)
  );

endmodule

// File: tb/sim_edge_link.sv
`timescale 1ns/1ps
module sim_edge_link;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        pv, pp;
  logic [63:0] pd;

  localparam int N = 3;
  int fwdL[N] = '{4, 0, 66};
  int ackL[N] = '{2, 0, 3};
  logic [63:0] wMask[N] = '{64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_00FF, {64{1'b1}}};

  logic        rdy[N], vld[N], ful[N];
  logic [63:0] dat[N];

  logic [31:0] d0; logic [7:0] d1; logic [63:0] d2;

  edge_link u0 (.clk(clk), .rst(rst), .pushValid(pv), .pushData(pd[31:0]),
    .pushReady(rdy[0]), .outValid(vld[0]), .outData(d0), .popReq(pp), .occFull(ful[0]));
  edge_link #(.WIDTH(8), .FWD_LAT(0), .ACK_LAT(0)) u1 (.clk(clk), .rst(rst), .pushValid(pv),
    .pushData(pd[7:0]), .pushReady(rdy[1]), .outValid(vld[1]), .outData(d1), .popReq(pp),
    .occFull(ful[1]));
  edge_link #(.WIDTH(64), .FWD_LAT(66), .ACK_LAT(3)) u2 (.clk(clk), .rst(rst), .pushValid(pv),
    .pushData(pd), .pushReady(rdy[2]), .outValid(vld[2]), .outData(d2), .popReq(pp),
    .occFull(ful[2]));

  assign dat[0] = 64'(d0);
  assign dat[1] = 64'(d1);
  assign dat[2] = d2;

  int nChk = 0, nBad = 0;
  int rSt[N], rCnt[N];
  logic [63:0] rWord[N];
  logic [63:0] sbWord[N];
  int pushes[N], pops[N];

  function automatic logic [63:0] expData(int i);
    return (rSt[i] == 2) ? rWord[i] : 64'd0;
  endfunction

  task automatic chk(string req, int i, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s inst%0d actual=%h expected=%h t=%0t", req, i, act, exp, $time);
    end
  endtask

  // Compare all instances against the phase model (called away from edges)
  task automatic compareAll();
    for (int i = 0; i < N; i++) begin
      chk("R6 ready", i, 64'(rdy[i]), 64'(rSt[i] == 0));
      chk("R3 valid", i, 64'(vld[i]), 64'(rSt[i] == 2));
      chk("R4 data", i, dat[i], expData(i));
      chk("R7 full", i, 64'(ful[i]), 64'(rSt[i] == 1 || rSt[i] == 2));
    end
  endtask

  // Scoreboard on observed handshakes (one-entry mailbox) before the edge
  task automatic scoreboard();
    for (int i = 0; i < N; i++) begin
      if (pv && rdy[i]) begin
        sbWord[i] = pd & wMask[i];
        pushes[i]++;
      end
      if (pp && vld[i]) begin
        chk("R10 order", i, dat[i], sbWord[i]);
        pops[i]++;
      end
      chk("R10 count", i, 64'(pushes[i] - pops[i] <= 1 && pushes[i] >= pops[i]), 64'd1);
    end
  endtask

  // Update model after an edge from inputs held across it
  task automatic modelEdge();
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        rSt[i] = 0; rCnt[i] = 0; rWord[i] = 0;
      end else begin
        case (rSt[i])
          0: if (pv) begin rSt[i] = 1; rCnt[i] = fwdL[i]; rWord[i] = pd & wMask[i]; end
          1: if (rCnt[i] != 0) rCnt[i]--; else rSt[i] = 2;
          2: if (pp) begin rSt[i] = 3; rCnt[i] = ackL[i]; end
          default: if (rCnt[i] != 0) rCnt[i]--; else rSt[i] = 0;
        endcase
      end
    end
  endtask

  task automatic cycle();
    scoreboard();
    @(posedge clk);
    #1;
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  int edges = 0;
  initial begin
    forever begin
      @(posedge clk);
      edges++;
      if (edges > 150000) begin
        nChk++; nBad++;
        $display("FAIL watchdog actual=%0d expected<150000", edges);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    for (int i = 0; i < N; i++) begin
      rSt[i] = 0; rCnt[i] = 0; rWord[i] = 0; sbWord[i] = 0; pushes[i] = 0; pops[i] = 0;
    end
    rst = 1'b1; pv = 1'b0; pp = 1'b0; pd = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state on every instance
    for (int i = 0; i < N; i++) begin
      chk("R1 ready", i, 64'(rdy[i]), 64'd1);
      chk("R1 valid", i, 64'(vld[i]), 64'd0);
      chk("R1 full", i, 64'(ful[i]), 64'd0);
      chk("R1 data", i, dat[i], 64'd0);
    end
    rst = 1'b0;

    // R8: worked case on u2, 67 edges after the push edge
    pv = 1'b1; pd = 64'd42; pp = 1'b0;
    cycle();
    pv = 1'b1; pd = 64'hDEAD_BEEF_0BAD_F00D;  // R2: stray push while forwarding
    for (int k = 1; k <= 66; k++) begin
      cycle();
      chk("R8 not yet", 2, 64'(vld[2]), 64'd0);
    end
    cycle();
    chk("R8 valid", 2, 64'(vld[2]), 64'd1);
    chk("R8 data", 2, dat[2], 64'd42);
    pv = 1'b0;

    // R9: zero latency, one forward cycle and one return cycle on u1
    for (int k = 0; k < 4; k++) cycle();
    pp = 1'b1;
    cycle();                                   // pop takes effect wherever valid
    pp = 1'b0;
    while (!(rdy[0] && rdy[1] && rdy[2])) cycle();
    pv = 1'b1; pd = 64'h77;
    cycle();                                   // push edge
    pv = 1'b0;
    chk("R9 fwd one cycle", 1, 64'(ful[1] && !vld[1]), 64'd1);
    cycle();
    chk("R9 held", 1, 64'(vld[1]), 64'd1);
    chk("R9 data", 1, dat[1], 64'h77);
    pp = 1'b1;
    cycle();
    pp = 1'b0;
    chk("R9 ret one cycle", 1, 64'(!rdy[1] && !ful[1]), 64'd1);
    cycle();
    chk("R9 ready again", 1, 64'(rdy[1]), 64'd1);

    // R5: stray pops while nothing is delivered
    pp = 1'b1;
    repeat (3) cycle();
    pp = 1'b0;

    // Random mixed traffic: R2, R3, R4, R5, R6, R7, R10
    for (int k = 0; k < 6000; k++) begin
      pv = ($urandom_range(0, 9) < 6);
      pp = ($urandom_range(0, 9) < 5);
      pd = {$urandom(), $urandom()};
      cycle();
    end
    pv = 1'b0; pp = 1'b0;

    // R10: end balance, at most one word inside each link
    for (int i = 0; i < N; i++)
      chk("R10 balance", i, 64'(pushes[i] - pops[i] == (rSt[i] == 1 || rSt[i] == 2)), 64'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule